// File: doc/BRIEF.md
# SD Card Command Path Controller

This block drives the command line of an SD/MMC card. When it is started, it takes a command index, a 32-bit argument and a set of options and builds a 48-bit command frame protected by a CRC7. It shifts the frame onto the line, one bit per card clock, starting with the most significant bit. It can then release the line and wait for the card to answer with a 48-bit short response or a 136-bit long response. It reports how the command ended with a one-cycle flag: command sent, response received, response CRC failure, or response timeout.

Two options change when and how a command runs. The first holds the frame back while the data path reports that a transfer is still in progress. The second turns off the response timeout, so that the controller waits until either an interrupt request or a response arrives. A third option replaces the programmed index with the fixed index 61. The payload of each response is kept in a capture register that stays valid until the next response replaces it. Clock division is outside the block: one `clk` cycle is one card bit time.

Top module: `sdcmd_ctrl`

## Requirements
- R1: One cycle after `go` is accepted in idle (with no hold in force), `cmd_oe` is high for exactly 48 cycles. During those cycles `cmd_out` carries, MSB first: a 0 bit, a 1 bit, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, register cleared to zero) over the first 40 bits, and a closing 1 bit.
- R2: When `force_ata` is high at launch, the index field of the frame is 61, whatever the value of `cmd_idx`.
- R3: When `resp_sel` is 2'b00 or 2'b10, no response is awaited. `sent_flag` pulses in the cycle after the last frame bit, and the block returns to idle.
- R4: When `resp_sel` is 2'b01, the block receives a 48-bit response that begins at the first 0 seen on `cmd_in`. It recomputes the CRC7 over the first 40 response bits and compares it with response bits 7..1. On a match it raises `resp_ok_flag`, otherwise `crc_fail_flag`. `resp_data[31:0]` takes response bits 39..8, and the upper bits become 0.
- R5: When `resp_sel` is 2'b11, the block receives a 136-bit response without checking its CRC and always raises `resp_ok_flag`. `resp_data` takes the last 128 bits received.
- R6: After the command end bit, the response start bit is accepted only within the first 64 sampling cycles. If the line is still high on the 64th cycle, `timeout_flag` pulses and the block goes idle.
- R7: When `hold_for_data` is high at launch and `data_busy` is high, the frame waits (with `busy` high and `cmd_oe` low) until `data_busy` is seen low. Transmission starts in the cycle after that.
- R8: When `wait_irq` is high at launch, no timeout occurs while waiting for a response. A high `irq_req` during the wait ends the command with `sent_flag`.
- R9: Nothing is transmitted while `go` is low. `go` and the command inputs have no effect on a command that is already running.
- R10: The four completion flags last one cycle each, at most one is high at a time, and `busy` is low whenever one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, accepted only when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_sel | input | 2 | Response kind: 00/10 none, 01 short, 11 long |
| hold_for_data | input | 1 | Wait for the data path to go quiet before sending |
| wait_irq | input | 1 | Disable the timeout and wait for an interrupt |
| force_ata | input | 1 | Send index 61 in place of `cmd_idx` |
| data_busy | input | 1 | Data path transfer in progress |
| irq_req | input | 1 | Interrupt request from the card side |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Command line drive value (1 when not sending) |
| cmd_oe | output | 1 | Command line output enable |
| busy | output | 1 | A command is in progress |
| sent_flag | output | 1 | Command ended without a response |
| resp_ok_flag | output | 1 | Response received correctly |
| crc_fail_flag | output | 1 | Short response CRC mismatch |
| timeout_flag | output | 1 | No response start bit in time |
| resp_data | output | 128 | Response capture register |

## Verification
The bench checks the timeout window at both edges. A start bit on the 64th cycle must be accepted, and a line left high through that cycle must time out. A counter that is off by one would either drop a late response or keep waiting for one more cycle. It uses the all-zero command (whose frame must end in 0x95) and a corrupted short-response CRC to catch a wrong polynomial, a wrong bit order or a check that never fails. It also pulses `go` with a new index during transmission, holds the frame back behind `data_busy`, and leaves the line idle for a long time in interrupt mode. A design that relaunched, sent early or timed out would corrupt the frame, raise `cmd_oe` too soon or raise the wrong flag.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned ARG_W     = 32;
  localparam int unsigned CRC_W     = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
  localparam int unsigned SHORT_LEN = 48;
  localparam int unsigned LONG_LEN  = 136;
  localparam int unsigned PAYLOAD_W = 128;
  localparam logic [IDX_W-1:0] ATA_IDX = 6'd61;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } cmd_state_t;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  assign fb = din ^ crc_q[W-1];

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sdcmd_tmo.sv
module sdcmd_tmo #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = en ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = en && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [IDX_W-1:0]     cmd_idx,
  input  logic [ARG_W-1:0]     cmd_arg,
  input  logic [1:0]           resp_sel,
  input  logic                 hold_for_data,
  input  logic                 wait_irq,
  input  logic                 force_ata,
  input  logic                 data_busy,
  input  logic                 irq_req,
  input  logic                 cmd_in,
  output logic                 cmd_out,
  output logic                 cmd_oe,
  output logic                 busy,
  output logic                 sent_flag,
  output logic                 resp_ok_flag,
  output logic                 crc_fail_flag,
  output logic                 timeout_flag,
  output logic [PAYLOAD_W-1:0] resp_data
);
  localparam int unsigned FIELD_W  = IDX_W + ARG_W;
  localparam int unsigned HDR_BITS = FIELD_W + 2;
  localparam int unsigned CNT_W    = $clog2(LONG_LEN);
  localparam int unsigned FSEL_W   = $clog2(FIELD_W);
  localparam int unsigned CSEL_W   = $clog2(CRC_W);
  localparam int unsigned SH_W     = PAYLOAD_W - 1;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] HDR_END    = CNT_W'(HDR_BITS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  cmd_state_t           state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FIELD_W-1:0]   field_q;
  logic [1:0]           rsel_q;
  logic                 irq_q;
  logic [SH_W-1:0]      sh_q, sh_d;
  logic [PAYLOAD_W-1:0] resp_q, resp_d;
  logic                 sent_q, ok_q, fail_q, tmo_q;
  logic                 sent_d, ok_d, fail_d, tmo_d;
  logic                 launch;
  logic [CRC_W-1:0]     crc;
  logic                 crc_clr, crc_en, crc_din;
  logic                 tmo_en, tmo_hit;
  logic [CNT_W-1:0]     fsel, csel, rx_last;
  logic                 tx_bit;

  assign launch  = (state_q == ST_IDLE) && go;
  assign rx_last = (rsel_q == 2'b11) ? LONG_LAST : SHORT_LAST;
  assign fsel    = CNT_W'(HDR_BITS - 1) - cnt_q;
  assign csel    = CNT_W'(SHORT_LEN - 2) - cnt_q;

  // transmit bit selection
  always_comb begin
    if (cnt_q == '0)             tx_bit = 1'b0;
    else if (cnt_q == CNT_W'(1)) tx_bit = 1'b1;
    else if (cnt_q < HDR_END)    tx_bit = field_q[fsel[FSEL_W-1:0]];
    else if (cnt_q < SHORT_LAST) tx_bit = crc[csel[CSEL_W-1:0]];
    else                         tx_bit = 1'b1;
  end

  assign cmd_oe  = (state_q == ST_SEND);
  assign cmd_out = cmd_oe ? tx_bit : 1'b1;
  assign busy    = (state_q != ST_IDLE);

  // shared CRC engine: frame bits on transmit, response bits on receive
  assign crc_clr = (state_q == ST_IDLE) || ((state_q == ST_SEND) && (cnt_q == SHORT_LAST));
  always_comb begin
    crc_en  = 1'b0;
    crc_din = cmd_in;
    case (state_q)
      ST_SEND: begin crc_en = (cnt_q < HDR_END); crc_din = tx_bit; end
      ST_WAIT: crc_en = !cmd_in;
      ST_RECV: crc_en = (cnt_q < HDR_END);
      default: crc_en = 1'b0;
    endcase
  end

  sdcmd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) i_crc (
    .clk(clk), .rst_n(rst_sync_n), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc)
  );

  assign tmo_en = (state_q == ST_WAIT) && !irq_q;

  sdcmd_tmo #(.LIMIT(TMO_CYCLES)) i_tmo (
    .clk(clk), .rst_n(rst_sync_n), .en(tmo_en), .expired(tmo_hit)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    resp_d  = resp_q;
    sent_d  = 1'b0;
    ok_d    = 1'b0;
    fail_d  = 1'b0;
    tmo_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        cnt_d   = '0;
        state_d = (hold_for_data && data_busy) ? ST_PEND : ST_SEND;
      end
      ST_PEND: if (!data_busy) state_d = ST_SEND;
      ST_SEND: begin
        if (cnt_q == SHORT_LAST) begin
          cnt_d = '0;
          if (rsel_q[0]) state_d = ST_WAIT;
          else begin state_d = ST_IDLE; sent_d = 1'b1; end
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_WAIT: begin
        if (!cmd_in) begin
          state_d = ST_RECV;
          cnt_d   = CNT_W'(1);
          sh_d    = {sh_q[SH_W-2:0], cmd_in};
        end else if (irq_q && irq_req) begin
          state_d = ST_IDLE; sent_d = 1'b1;
        end else if (tmo_hit) begin
          state_d = ST_IDLE; tmo_d = 1'b1;
        end
      end
      ST_RECV: begin
        sh_d = {sh_q[SH_W-2:0], cmd_in};
        if (cnt_q == rx_last) begin
          state_d = ST_IDLE;
          if (rsel_q == 2'b11) begin
            resp_d = {sh_q, cmd_in};
            ok_d   = 1'b1;
          end else begin
            resp_d = {{(PAYLOAD_W-ARG_W){1'b0}}, sh_q[ARG_W+CRC_W-1:CRC_W]};
            if (sh_q[CRC_W-1:0] == crc) ok_d = 1'b1;
            else                        fail_d = 1'b1;
          end
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      resp_q  <= '0;
      sent_q  <= 1'b0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      resp_q  <= resp_d;
      sent_q  <= sent_d;
      ok_q    <= ok_d;
      fail_q  <= fail_d;
      tmo_q   <= tmo_d;
    end
  end

  // command fields, loaded only on launch
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      field_q <= '0;
      rsel_q  <= '0;
      irq_q   <= 1'b0;
    end else if (launch) begin
      field_q <= {force_ata ? ATA_IDX : cmd_idx, cmd_arg};
      rsel_q  <= resp_sel;
      irq_q   <= wait_irq;
    end
  end

  assign sent_flag     = sent_q;
  assign resp_ok_flag  = ok_q;
  assign crc_fail_flag = fail_q;
  assign timeout_flag  = tmo_q;
  assign resp_data     = resp_q;

  // R1
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(cmd_oe) |-> (cmd_out == 1'b0));
  // R4
  crc_fail_short_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fail_q |-> (rsel_q == 2'b01));
  // R5
  resp_ok_kind_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ok_q |-> rsel_q[0]);
  // R8
  tmo_not_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmo_q |-> !irq_q);
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_PEND && data_busy) |=> !cmd_oe);
  // R10
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({sent_q, ok_q, fail_q, tmo_q}));
  // R10
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sent_q || ok_q || fail_q || tmo_q) |-> !busy);
endmodule

// File: tb/test_sdcmd_ctrl.sv
`timescale 1ns/1ps
module test_sdcmd_ctrl;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         go, hold_for_data, wait_irq, force_ata, data_busy, irq_req, cmd_in;
  logic [5:0]   cmd_idx;
  logic [31:0]  cmd_arg;
  logic [1:0]   resp_sel;
  logic         cmd_out, cmd_oe, busy;
  logic         sent_flag, resp_ok_flag, crc_fail_flag, timeout_flag;
  logic [127:0] resp_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  sdcmd_ctrl i_sdcmd_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .resp_sel(resp_sel), .hold_for_data(hold_for_data), .wait_irq(wait_irq),
    .force_ata(force_ata), .data_busy(data_busy), .irq_req(irq_req), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .sent_flag(sent_flag),
    .resp_ok_flag(resp_ok_flag), .crc_fail_flag(crc_fail_flag),
    .timeout_flag(timeout_flag), .resp_data(resp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [135:0] act, input logic [135:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7_of(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] ix, input logic [31:0] a);
    return {2'b01, ix, a, crc7_of({2'b01, ix, a}), 1'b1};
  endfunction

  function automatic logic [3:0] flags_now();
    return {sent_flag, resp_ok_flag, crc_fail_flag, timeout_flag};
  endfunction

  task automatic launch(input logic [5:0] ix, input logic [31:0] a, input logic [1:0] rs,
                        input logic ata, input logic hold, input logic irq);
    cmd_idx = ix; cmd_arg = a; resp_sel = rs; force_ata = ata;
    hold_for_data = hold; wait_irq = irq; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  // samples the 48 frame bits; R9: a go pulse with a new index during sending
  task automatic watch_send(input logic [47:0] exp, output logic [47:0] got);
    int oe_bad = 0;
    for (int i = 0; i < 48; i++) begin
      got[47-i] = cmd_out;
      if (!cmd_oe) oe_bad++;
      if (i == 5) begin go = 1'b1; cmd_idx = ~cmd_idx; cmd_arg = ~cmd_arg; end
      if (i == 6) go = 1'b0;
      @(negedge clk);
    end
    chk(got == exp, "R1", "frame bits", got, exp);
    chk(oe_bad == 0, "R1", "cmd_oe during frame", oe_bad, 0);
    chk(cmd_oe == 1'b0, "R1", "cmd_oe after 48 bits", cmd_oe, 0);
  endtask

  task automatic drive_resp(input int delay, input int len, input logic [135:0] f);
    for (int n = 0; n < delay; n++) begin cmd_in = 1'b1; @(negedge clk); end
    for (int j = 0; j < len; j++) begin cmd_in = f[len-1-j]; @(negedge clk); end
    cmd_in = 1'b1;
  endtask

  // R10: expected flag now, all clear one cycle later
  task automatic end_flags(input logic [3:0] exp, input string req);
    chk(flags_now() == exp, req, "completion flags", flags_now(), exp);
    chk(busy == 1'b0, req, "busy at completion", busy, 0);
    @(negedge clk);
    chk(flags_now() == 4'b0, "R10", "flags one cycle only", flags_now(), 0);
  endtask

  task automatic do_cmd(input logic [5:0] ix, input logic [31:0] a, input logic [1:0] rs,
                        input logic ata, input int delay, input logic corrupt);
    logic [5:0]   eix;
    logic [47:0]  got;
    logic [31:0]  status;
    logic [127:0] payload;
    logic [47:0]  sf;
    eix = ata ? 6'd61 : ix;
    launch(ix, a, rs, ata, 1'b0, 1'b0);
    watch_send(cmd_frame(eix, a), got);
    if (ata) chk(got[45:40] == 6'd61, "R2", "forced index", got[45:40], 61);
    if (!rs[0]) begin
      end_flags(4'b1000, "R3");
    end else if (rs == 2'b01) begin
      status = $urandom;
      sf = {2'b00, eix, status, crc7_of({2'b00, eix, status}), 1'b1};
      if (corrupt) sf[3] = ~sf[3];
      drive_resp(delay, 48, {88'b0, sf});
      end_flags(corrupt ? 4'b0010 : 4'b0100, "R4");
      chk(resp_data == {96'b0, status}, "R4", "short capture", resp_data, {96'b0, status});
    end else begin
      payload = {$urandom, $urandom, $urandom, $urandom};
      drive_resp(delay, 136, {8'h3F, payload});
      end_flags(4'b0100, "R5");
      chk(resp_data == payload, "R5", "long capture", resp_data, payload);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R10 watchdog expired: act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] got;
    int bad;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; go = 1'b0; cmd_idx = '0; cmd_arg = '0; resp_sel = '0;
    hold_for_data = 1'b0; wait_irq = 1'b0; force_ata = 1'b0;
    data_busy = 1'b0; irq_req = 1'b0; cmd_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(cmd_oe == 0 && cmd_out == 1 && busy == 0, "R9", "reset outputs",
        {cmd_oe, cmd_out, busy}, 3'b010);
    chk(flags_now() == 0 && resp_data == 0, "R10", "reset flags/capture",
        {flags_now(), resp_data}, 0);

    // R9: no go, no activity
    bad = 0;
    for (int n = 0; n < 10; n++) begin if (cmd_oe || busy) bad++; @(negedge clk); end
    chk(bad == 0, "R9", "idle without go", bad, 0);

    // R1: all-zero command ends in 0x95
    launch(6'd0, 32'd0, 2'b00, 1'b0, 1'b0, 1'b0);
    watch_send(cmd_frame(6'd0, 32'd0), got);
    chk(got[7:0] == 8'h95, "R1", "CRC tail of zero command", got[7:0], 8'h95);
    end_flags(4'b1000, "R3");

    // R3: code 10 is also no response
    do_cmd(6'd17, 32'hDEAD_BEEF, 2'b10, 1'b0, 0, 1'b0);
    // R2: forced index
    do_cmd(6'd17, 32'h1234_5678, 2'b00, 1'b1, 0, 1'b0);
    // R4: good and corrupted short responses
    do_cmd(6'd13, 32'h0001_0000, 2'b01, 1'b0, 3, 1'b0);
    do_cmd(6'd13, 32'h0001_0000, 2'b01, 1'b0, 0, 1'b1);
    // R5: long response
    do_cmd(6'd2, 32'h0, 2'b11, 1'b0, 5, 1'b0);
    // R6: start bit on the last allowed cycle
    do_cmd(6'd55, 32'hA5A5_5A5A, 2'b01, 1'b0, 63, 1'b0);

    // R6: no start bit at all
    launch(6'd8, 32'h1AA, 2'b01, 1'b0, 1'b0, 1'b0);
    watch_send(cmd_frame(6'd8, 32'h1AA), got);
    for (int n = 0; n < 63; n++) begin cmd_in = 1'b1; @(negedge clk); end
    chk(busy == 1 && timeout_flag == 0, "R6", "no timeout before 64th cycle",
        {busy, timeout_flag}, 2'b10);
    @(negedge clk);
    end_flags(4'b0001, "R6");

    // R8: interrupt wait, no timeout
    launch(6'd39, 32'h77, 2'b01, 1'b0, 1'b0, 1'b1);
    watch_send(cmd_frame(6'd39, 32'h77), got);
    bad = 0;
    for (int n = 0; n < 100; n++) begin if (timeout_flag || !busy) bad++; @(negedge clk); end
    chk(bad == 0, "R8", "waiting past timeout window", bad, 0);
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    end_flags(4'b1000, "R8");

    // R7: hold behind data_busy
    data_busy = 1'b1;
    launch(6'd24, 32'hCAFE, 2'b00, 1'b0, 1'b1, 1'b0);
    bad = 0;
    for (int n = 0; n < 20; n++) begin if (cmd_oe || !busy) bad++; @(negedge clk); end
    chk(bad == 0, "R7", "held while data busy", bad, 0);
    data_busy = 1'b0;
    @(negedge clk);
    chk(cmd_oe == 1'b1, "R7", "sends after data end", cmd_oe, 1);
    watch_send(cmd_frame(6'd24, 32'hCAFE), got);
    end_flags(4'b1000, "R7");

    // R7: without the option data_busy is ignored
    data_busy = 1'b1;
    launch(6'd25, 32'hBEEF, 2'b00, 1'b0, 1'b0, 1'b0);
    chk(cmd_oe == 1'b1, "R7", "no hold without option", cmd_oe, 1);
    watch_send(cmd_frame(6'd25, 32'hBEEF), got);
    data_busy = 1'b0;
    end_flags(4'b1000, "R3");

    // random commands
    for (int k = 0; k < 30; k++) begin
      logic [1:0] rs = 2'($urandom % 4);
      do_cmd(6'($urandom), $urandom, rs, 1'($urandom % 4 == 0),
             int'($urandom % 30), 1'($urandom % 3 == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule